// File: doc/BRIEF.md
# Cell Selection Modulator for One Cascaded H-Bridge Phase Leg

This block turns a signed per-phase voltage reference into one command per H-bridge cell of a cascaded phase leg. Each command is one of bypass, direct insertion, reverse insertion or modulated. At every main control event it samples its inputs. It divides the reference magnitude by the nominal cell voltage. The whole part of the quotient is the number of cells held fully inserted. The remainder, scaled to a fraction of one cell voltage, is the duty of a single modulated cell. The block ranks the cells by their measured capacitor voltages. When the phase is charging, the weakest cells receive the insertions. When it is discharging, the strongest cells receive them.

The main event comes from the top and the bottom of the triangular carrier. A secondary event arrives midway between two main events. While the sampled RMS current is above a programmable threshold, the block takes the charge direction once per main event from the current sign. The secondary event then leaves the pattern untouched. At or below the threshold, the leg is in low-current standby. The block then ignores the current sign and uses a fixed order: the discharging pattern in the first half-period and the charging pattern in the second. A delay-configuration input swaps that order to match a controller that has a one-sample delay.

A sequencer steps through six states: `ST_IDLE`, `ST_COMPUTE`, `ST_APPLY_A`, `ST_HOLD_A`, `ST_APPLY_B` and `ST_HOLD_B`. A main event in `ST_IDLE`, `ST_HOLD_A` or `ST_HOLD_B` moves it to `ST_COMPUTE`. When both the divider and the ranker are finished, it moves to `ST_APPLY_A` and then to `ST_HOLD_A`. A secondary event in `ST_HOLD_A` moves it to `ST_APPLY_B` and then to `ST_HOLD_B`. If a main event and a secondary event arrive together in `ST_HOLD_A`, the main event wins.

Top module: `cell_sel_mod`

## Requirements
- R1: While reset is active, and after it is released until the first main event takes effect, every cell command is bypass (00) and the duty is zero.
- R2: With k = floor(|vref|/vnom) below N, exactly k cells are inserted, and the duty equals floor((|vref| mod vnom)·2^FW / vnom).
- R3: Command codes are 00 bypass, 01 direct, 10 reverse and 11 modulated, with cell i in bits [2i+1:2i]. Inserted cells use 01 when vref ≥ 0 and 10 when vref < 0. At most one cell carries 11.
- R4: In the charging pattern, the ascending voltage rank decides the roles. The cells of rank 0 to k−1 are inserted, the cell of rank k is modulated, and all others are bypassed.
- R5: In the discharging pattern, the same allocation applies to the descending voltage rank, so the highest-voltage cells are used first.
- R6: Outside standby, the pattern is charging when the sign of vref equals the current sign, and discharging otherwise. The current sign is given by cur_neg = 1 for negative, and vref = 0 counts as non-negative.
- R7: Equal cell voltages are ranked with the lower cell index first, in both directions.
- R8: When k ≥ N, all N cells are inserted, no cell is modulated and the duty is zero.
- R9: When the sampled irms ≤ irms_thresh, standby applies. With delay_cfg = 0, the first half-period uses the discharging pattern and the second half-period uses the charging pattern, whatever the values of cur_neg and the sign of vref.
- R10: In standby with delay_cfg = 1, the order is reversed: charging first, then discharging.
- R11: Outside standby, a secondary event leaves the commands and the duty unchanged.
- R12: Inputs are sampled only at an accepted main event. Main events during `ST_COMPUTE` are ignored. Secondary events outside `ST_HOLD_A` are ignored. Outputs change only within VW+FW+4 cycles after an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_evt | input | 1 | One-cycle pulse at a carrier peak or valley |
| mid_evt | input | 1 | One-cycle pulse midway between main events |
| vref | input | VW | Signed voltage reference |
| vnom | input | VW | Nominal cell voltage, unsigned |
| cell_v | input | N·VW | Measured cell voltages, cell i in bits [i·VW +: VW] |
| cur_neg | input | 1 | Phase current is negative |
| irms | input | IRW | RMS current magnitude |
| irms_thresh | input | IRW | Standby threshold |
| delay_cfg | input | 1 | Controller has a one-sample delay |
| cell_cmd | output | 2·N | Per-cell command, 2 bits per cell |
| duty | output | FW | Duty of the modulated cell, fraction of 2^FW |

## Verification
The bench sweeps the reference across both polarities and both current signs. It runs into saturation, so an allocator that is off by one at k = N would show an extra modulated cell or a nonzero duty. It loads equal voltages and pairs of equal voltages: a ranker that breaks ties wrongly would hand an insertion to a higher index. It places the irms value exactly on the threshold and one above it, and it toggles delay_cfg. These cases catch a standby test with the wrong comparison and a swapped half-period order. Finally, it fires stray main and secondary events while the block is computing, with changed inputs. A design that restarted on them would give the commands of the later inputs.

// File: rtl/csm_pkg.sv
package csm_pkg;

    typedef enum logic [1:0] {
        CMD_BYPASS  = 2'b00,
        CMD_DIRECT  = 2'b01,
        CMD_REVERSE = 2'b10,
        CMD_MOD     = 2'b11
    } cell_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COMPUTE,
        ST_APPLY_A,
        ST_HOLD_A,
        ST_APPLY_B,
        ST_HOLD_B
    } ctl_state_e;

endpackage

// File: rtl/csm_divider.sv
// Restoring divider: quotient of {num, FW zeros} / den, one bit per clock.
module csm_divider #(
    parameter int NUM_W = 12,
    parameter int FW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [NUM_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] int_part,
    output logic [FW-1:0]    frac_part
);
    localparam int DW = NUM_W + FW;
    localparam int CW = $clog2(DW + 1);

    logic [NUM_W:0]   rem_q;
    logic [DW-1:0]    dvd_q;
    logic [NUM_W-1:0] den_q;
    logic [CW-1:0]    cnt_q;
    logic             busy_q;

    logic [NUM_W:0] trial_sh;
    logic [NUM_W:0] trial_sub;
    logic           trial_ok;

    always_comb begin
        trial_sh  = {rem_q[NUM_W-1:0], dvd_q[DW-1]};
        trial_ok  = (trial_sh >= {1'b0, den_q});
        trial_sub = trial_sh - {1'b0, den_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            dvd_q  <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done   <= 1'b0;
        end else if (start) begin
            rem_q  <= '0;
            dvd_q  <= {num, {FW{1'b0}}};
            den_q  <= den;
            cnt_q  <= CW'(DW);
            busy_q <= 1'b1;
            done   <= 1'b0;
        end else if (busy_q) begin
            rem_q <= trial_ok ? trial_sub : trial_sh;
            dvd_q <= {dvd_q[DW-2:0], trial_ok};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
                busy_q <= 1'b0;
                done   <= 1'b1;
            end
        end
    end

    assign int_part  = dvd_q[DW-1:FW];
    assign frac_part = dvd_q[FW-1:0];

endmodule

// File: rtl/csm_ranker.sv
// Sequential rank counter: one cell per clock, ascending and descending
// ranks with the lower index first on ties.
module csm_ranker #(
    parameter int N  = 9,
    parameter int VW = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [N*VW-1:0] cells_in,
    output logic            done,
    output logic [N*$clog2(N)-1:0] rank_up,
    output logic [N*$clog2(N)-1:0] rank_dn
);
    localparam int RW = $clog2(N);

    logic [VW-1:0] cv_q    [N];
    logic [RW-1:0] up_q    [N];
    logic [RW-1:0] dn_q    [N];
    logic [RW-1:0] idx_q;
    logic          busy_q;

    int up_cnt;
    int dn_cnt;

    always_comb begin
        up_cnt = 0;
        dn_cnt = 0;
        for (int j = 0; j < N; j++) begin
            if ((cv_q[j] < cv_q[idx_q]) ||
                ((cv_q[j] == cv_q[idx_q]) && (j < int'(idx_q))))
                up_cnt = up_cnt + 1;
            if ((cv_q[j] > cv_q[idx_q]) ||
                ((cv_q[j] == cv_q[idx_q]) && (j < int'(idx_q))))
                dn_cnt = dn_cnt + 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                cv_q[i] <= '0;
                up_q[i] <= '0;
                dn_q[i] <= '0;
            end
            idx_q  <= '0;
            busy_q <= 1'b0;
            done   <= 1'b0;
        end else if (start) begin
            for (int i = 0; i < N; i++)
                cv_q[i] <= cells_in[i*VW +: VW];
            idx_q  <= '0;
            busy_q <= 1'b1;
            done   <= 1'b0;
        end else if (busy_q) begin
            up_q[idx_q] <= RW'(up_cnt);
            dn_q[idx_q] <= RW'(dn_cnt);
            if (idx_q == RW'(N - 1)) begin
                busy_q <= 1'b0;
                done   <= 1'b1;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_flat
        assign rank_up[g*RW +: RW] = up_q[g];
        assign rank_dn[g*RW +: RW] = dn_q[g];
    end

endmodule

// File: rtl/csm_alloc.sv
// Maps ranks and the inserted-cell count to per-cell commands.
module csm_alloc
    import csm_pkg::*;
#(
    parameter int N  = 9,
    parameter int VW = 12,
    parameter int FW = 8
) (
    input  logic [N*$clog2(N)-1:0] rank_flat,
    input  logic [VW-1:0]          int_part,
    input  logic [FW-1:0]          frac_part,
    input  logic                   ref_neg,
    output logic [2*N-1:0]         cmd_flat,
    output logic [FW-1:0]          duty_o
);
    localparam int RW = $clog2(N);
    localparam int KW = $clog2(N + 1);

    logic          sat;
    logic [KW-1:0] k_cnt;

    assign sat    = (int_part >= VW'(N));
    assign k_cnt  = sat ? KW'(N) : KW'(int_part);
    assign duty_o = sat ? '0 : frac_part;

    for (genvar g = 0; g < N; g++) begin : g_cell
        logic [KW-1:0] r_ext;
        cell_cmd_e     cmd_g;
        assign r_ext = KW'(rank_flat[g*RW +: RW]);
        always_comb begin
            if (r_ext < k_cnt)
                cmd_g = ref_neg ? CMD_REVERSE : CMD_DIRECT;
            else if (r_ext == k_cnt)
                cmd_g = CMD_MOD;
            else
                cmd_g = CMD_BYPASS;
        end
        assign cmd_flat[2*g +: 2] = cmd_g;
    end

endmodule

// File: rtl/cell_sel_mod.sv
module cell_sel_mod
    import csm_pkg::*;
#(
    parameter int N   = 9,
    parameter int VW  = 12,
    parameter int FW  = 8,
    parameter int IRW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 main_evt,
    input  logic                 mid_evt,
    input  logic signed [VW-1:0] vref,
    input  logic [VW-1:0]        vnom,
    input  logic [N*VW-1:0]      cell_v,
    input  logic                 cur_neg,
    input  logic [IRW-1:0]       irms,
    input  logic [IRW-1:0]       irms_thresh,
    input  logic                 delay_cfg,
    output logic [2*N-1:0]       cell_cmd,
    output logic [FW-1:0]        duty
);
    localparam int RW = $clog2(N);

    ctl_state_e state_q, state_d;

    logic          main_ok;
    logic          ref_neg_q, standby_q, first_chg_q;
    logic          use_chg;
    logic [VW-1:0] vref_mag;

    logic          div_done, rank_done;
    logic [VW-1:0] int_part;
    logic [FW-1:0] frac_part;
    logic [N*RW-1:0] rank_up, rank_dn, rank_sel;
    logic [2*N-1:0]  alloc_cmd;
    logic [FW-1:0]   alloc_duty;

    assign main_ok  = main_evt && ((state_q == ST_IDLE) ||
                                   (state_q == ST_HOLD_A) ||
                                   (state_q == ST_HOLD_B));
    assign vref_mag = vref[VW-1] ? (~vref + 1'b1) : vref;

    csm_divider #(.NUM_W(VW), .FW(FW)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (main_ok),
        .num       (vref_mag),
        .den       (vnom),
        .done      (div_done),
        .int_part  (int_part),
        .frac_part (frac_part)
    );

    csm_ranker #(.N(N), .VW(VW)) u_rank (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (main_ok),
        .cells_in (cell_v),
        .done     (rank_done),
        .rank_up  (rank_up),
        .rank_dn  (rank_dn)
    );

    // Sampled mode bits, captured only at an accepted main event.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_neg_q   <= 1'b0;
            standby_q   <= 1'b0;
            first_chg_q <= 1'b0;
        end else if (main_ok) begin
            ref_neg_q <= vref[VW-1];
            standby_q <= (irms <= irms_thresh);
            if (irms <= irms_thresh)
                first_chg_q <= delay_cfg;
            else
                first_chg_q <= (vref[VW-1] == cur_neg);
        end
    end

    assign use_chg  = ((state_q == ST_APPLY_B) && standby_q) ? ~first_chg_q
                                                              : first_chg_q;
    assign rank_sel = use_chg ? rank_up : rank_dn;

    csm_alloc #(.N(N), .VW(VW), .FW(FW)) u_alloc (
        .rank_flat (rank_sel),
        .int_part  (int_part),
        .frac_part (frac_part),
        .ref_neg   (ref_neg_q),
        .cmd_flat  (alloc_cmd),
        .duty_o    (alloc_duty)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (main_ok) state_d = ST_COMPUTE;
            ST_COMPUTE: if (div_done && rank_done) state_d = ST_APPLY_A;
            ST_APPLY_A: state_d = ST_HOLD_A;
            ST_HOLD_A: begin
                if (main_ok)      state_d = ST_COMPUTE;
                else if (mid_evt) state_d = ST_APPLY_B;
            end
            ST_APPLY_B: state_d = ST_HOLD_B;
            ST_HOLD_B:  if (main_ok) state_d = ST_COMPUTE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs: loaded only in the two apply states.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_cmd <= '0;
            duty     <= '0;
        end else if ((state_q == ST_APPLY_A) || (state_q == ST_APPLY_B)) begin
            cell_cmd <= alloc_cmd;
            duty     <= alloc_duty;
        end
    end

endmodule

// File: rtl/csm_checker.sv
module csm_checker #(
    parameter int N  = 9,
    parameter int VW = 12,
    parameter int FW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           main_evt,
    input logic           mid_evt,
    input logic [2*N-1:0] cell_cmd,
    input logic [FW-1:0]  duty
);
    localparam int WIN = VW + FW + 4;
    localparam int SW  = $clog2(WIN + 2);

    logic [N-1:0]  mod_f, dir_f, rev_f;
    logic [SW-1:0] since_q;

    for (genvar g = 0; g < N; g++) begin : g_f
        assign mod_f[g] = (cell_cmd[2*g +: 2] == 2'b11);
        assign dir_f[g] = (cell_cmd[2*g +: 2] == 2'b01);
        assign rev_f[g] = (cell_cmd[2*g +: 2] == 2'b10);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  since_q <= SW'(WIN + 1);
        else if (main_evt || mid_evt) since_q <= '0;
        else if (since_q != SW'(WIN + 1)) since_q <= since_q + 1'b1;
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (cell_cmd == '0 && duty == '0));

    a_r3_single_mod: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mod_f));

    a_r3_one_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        !((|dir_f) && (|rev_f)));

    a_r8_sat_duty: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_f == '0) |-> (duty == '0));

    a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(cell_cmd) && $stable(duty)) |-> (since_q <= SW'(WIN)));

endmodule

bind cell_sel_mod csm_checker #(.N(N), .VW(VW), .FW(FW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .main_evt (main_evt),
    .mid_evt  (mid_evt),
    .cell_cmd (cell_cmd),
    .duty     (duty)
);

// File: tb/tb_cell_sel_mod.sv
module tb_cell_sel_mod;
    localparam int N = 9;
    localparam int VW = 12;
    localparam int FW = 8;
    localparam int IRW = 12;
    localparam int CLK_PERIOD = 10;
    localparam int THRESH = 30;

    logic clk = 0;
    logic rst_n = 0;
    logic main_evt = 0, mid_evt = 0;
    logic signed [VW-1:0] vref = '0;
    logic [VW-1:0] vnom = VW'(100);
    logic [N*VW-1:0] cell_v = '0;
    logic cur_neg = 0;
    logic [IRW-1:0] irms = '0;
    logic [IRW-1:0] irms_thresh = IRW'(THRESH);
    logic delay_cfg = 0;
    logic [2*N-1:0] cell_cmd;
    logic [FW-1:0] duty;

    int checks = 0;
    int failures = 0;
    int cv[N];

    always #(CLK_PERIOD/2) clk = ~clk;

    cell_sel_mod #(.N(N), .VW(VW), .FW(FW), .IRW(IRW)) dut (
        .clk(clk), .rst_n(rst_n), .main_evt(main_evt), .mid_evt(mid_evt),
        .vref(vref), .vnom(vnom), .cell_v(cell_v), .cur_neg(cur_neg),
        .irms(irms), .irms_thresh(irms_thresh), .delay_cfg(delay_cfg),
        .cell_cmd(cell_cmd), .duty(duty)
    );

    function automatic void model(input int vr, input int vn, input bit chg,
                                  output logic [2*N-1:0] ecmd,
                                  output logic [FW-1:0] eduty);
        int mag, q, ip, k, r;
        mag = (vr < 0) ? -vr : vr;
        q = (mag * (1 << FW)) / vn;
        ip = q >> FW;
        k = (ip >= N) ? N : ip;
        eduty = (ip >= N) ? '0 : FW'(q % (1 << FW));
        for (int i = 0; i < N; i++) begin
            r = 0;
            for (int j = 0; j < N; j++) begin
                if ((chg ? (cv[j] < cv[i]) : (cv[j] > cv[i])) ||
                    (cv[j] == cv[i] && j < i))
                    r++;
            end
            if (r < k)       ecmd[2*i +: 2] = (vr < 0) ? 2'b10 : 2'b01;
            else if (r == k) ecmd[2*i +: 2] = 2'b11;
            else             ecmd[2*i +: 2] = 2'b00;
        end
    endfunction

    task automatic load_cells(input int kind, input int seed);
        for (int i = 0; i < N; i++) begin
            case (kind)
                0: cv[i] = ((seed * 29 + i * i * 13 + i * 7) % 200) + 400;
                1: cv[i] = 500;
                default: cv[i] = 520 - (i / 2) * 10;
            endcase
            cell_v[i*VW +: VW] = VW'(cv[i]);
        end
    endtask

    task automatic pulse_main();
        @(negedge clk) main_evt = 1;
        @(negedge clk) main_evt = 0;
    endtask

    task automatic pulse_mid();
        @(negedge clk) mid_evt = 1;
        @(negedge clk) mid_evt = 0;
    endtask

    task automatic settle();
        repeat (30) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [2*N-1:0] ecmd,
                         input logic [FW-1:0] eduty);
        checks++;
        if (cell_cmd !== ecmd || duty !== eduty) begin
            failures++;
            $display("FAIL %s cmd=%h exp=%h duty=%0d exp=%0d",
                     tag, cell_cmd, ecmd, duty, eduty);
        end
    endtask

    task automatic run_case(input int vr, input int vn, input bit cneg,
                            input int irv, input bit dly,
                            input string tag_a, input string tag_b);
        bit sb, first, second;
        logic [2*N-1:0] ec;
        logic [FW-1:0] ed;
        vref = VW'(vr); vnom = VW'(vn); cur_neg = cneg;
        irms = IRW'(irv); delay_cfg = dly;
        pulse_main();
        settle();
        sb = (irv <= THRESH);
        first = sb ? dly : ((vr < 0) == cneg);
        second = sb ? !first : first;
        model(vr, vn, first, ec, ed);
        check(tag_a, ec, ed);
        pulse_mid();
        settle();
        model(vr, vn, second, ec, ed);
        check(tag_b, ec, ed);
    endtask

    initial begin
        logic [2*N-1:0] ec;
        logic [FW-1:0] ed;
        load_cells(0, 1);
        repeat (3) @(negedge clk);
        check("R1 in reset", '0, '0);
        rst_n = 1;
        pulse_mid();
        settle();
        check("R1 R12 idle mid ignored", '0, '0);

        // Polarity, count, duty, direction and saturation sweep.
        for (int vn = 100; vn <= 230; vn += 130) begin
            for (int vr = -2048; vr <= 2047; vr += 61) begin
                for (int c = 0; c < 2; c++) begin
                    bit sat;
                    load_cells(0, vr + c);
                    sat = (((vr < 0) ? -vr : vr) / vn) >= N;
                    run_case(vr, vn, c[0], 500, 0,
                             sat ? "R8" : "R2 R3 R4 R5 R6", "R11");
                end
            end
        end
        load_cells(0, 7);
        run_case(900, 100, 0, 500, 0, "R8 exact N", "R11");
        run_case(899, 100, 1, 500, 0, "R2 N-1 cells", "R11");
        run_case(0, 100, 1, 500, 0, "R6 zero ref", "R11");
        run_case(-900, 100, 1, 500, 0, "R8 negative", "R11");

        // Ties.
        for (int kind = 1; kind <= 2; kind++) begin
            load_cells(kind, 0);
            for (int vr = -650; vr <= 650; vr += 130) begin
                run_case(vr, 100, 0, 500, 0, "R7 tie", "R7 R11");
                run_case(vr, 100, 1, 500, 0, "R7 tie", "R7 R11");
            end
        end

        // Standby order and threshold edge.
        for (int s = 0; s < 6; s++) begin
            load_cells(0, 40 + s);
            run_case(-420 + s * 170, 100, s[0], s * 6, 0, "R9 first", "R9 second");
            run_case(-420 + s * 170, 100, s[1], s * 6, 1, "R10 first", "R10 second");
        end
        run_case(333, 100, 1, THRESH, 0, "R9 at thresh", "R9 at thresh");
        run_case(333, 100, 1, THRESH + 1, 0, "R6 above thresh", "R11 above thresh");

        // Stray events while computing, with changed inputs.
        load_cells(0, 77);
        vref = VW'(350); vnom = VW'(100); cur_neg = 0;
        irms = IRW'(500); delay_cfg = 0;
        pulse_main();
        repeat (3) @(negedge clk);
        model(350, 100, 1, ec, ed);
        vref = VW'(-777); cur_neg = 1;
        @(negedge clk) begin main_evt = 1; mid_evt = 1; end
        @(negedge clk) begin main_evt = 0; mid_evt = 0; end
        settle();
        check("R12 stray events", ec, ed);
        pulse_mid();
        settle();
        check("R12 after stray", ec, ed);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule